// File: doc/BRIEF.md
# GPIO Port with Sleep Pin Lock

An 8-bit general-purpose I/O port whose pin conditions survive a deep-sleep state in which the supply to its configuration registers is removed. Software programs direction, output value, pull enable, edge select and interrupt enable through a simple register bus, and reads the synchronised pin levels and the edge flags. When the system enters deep sleep, a hold stage freezes the pad drive, pull and interrupt configuration, and a lock bit is set. The loss of supply is modelled as a pulse on a separate register-domain reset, which wipes the configuration registers but not the hold stage, the lock or the flags.

While asleep, a selected edge on an enabled pin raises a wake request. After waking, software reprograms the registers while the pins stay frozen, then writes zero to the lock bit. The pads then follow the new register contents, and the flags show every pin that saw an edge during sleep.

The register bus takes one access per cycle and never stalls. Reads are combinational. A write takes effect at the clock edge on which it is presented. No back-pressure exists on this interface.

Top module: `gpio_sleep_port`

## Requirements
- R1: Register offsets on `bus_addr` are: 0 direction (1 = output), 1 output value, 2 pull enable, 3 edge select, 4 interrupt enable, 5 edge flags (writing 1 clears a bit), 6 lock (bit 0), 7 synchronised pin levels (read only). Reading offsets 0 to 4 returns the last value written.
- R2: After power-on reset, every register reads 0, the lock is clear, `pad_oe`, `pad_out` and `pad_pull_en` are 0, and `wake_req` is 0.
- R3: While unlocked, `pad_oe` equals the direction register, `pad_out` equals output AND direction, and `pad_pull_en` equals pull AND NOT direction.
- R4: A rising edge on `sleep_i` sets the lock. From then on the pads keep the values they had just before entry, including across a `dom_rst_n` pulse.
- R5: A low pulse on `dom_rst_n` returns the registers at offsets 0 to 4 to 0. The lock and the edge flags are not affected.
- R6: While the lock is set, writes at offsets 0 to 4 update the readback value but leave `pad_oe`, `pad_out` and `pad_pull_en` unchanged.
- R7: Writing 0 to bit 0 at offset 6 clears the lock. The pads then follow the current register contents as in R3.
- R8: A flag bit is set by a rising edge on its pin when the effective edge-select bit is 0, and by a falling edge when it is 1, regardless of the interrupt enable. The flag reads as set on the third rising clock edge after the pin changes, and not before.
- R9: Writing 1s at offset 5 clears those flags only while the lock is clear. While the lock is set, the write is ignored.
- R10: While `sleep_i` is high, `wake_req` goes high and stays high after a selected edge on a pin whose interrupt enable was set at entry and whose flag was clear at entry. Edges on other pins do not raise it. `wake_req` is low one cycle after `sleep_i` is low.
- R11: Edges on several pins during sleep set all their flags, and all stay set after wake.
- R12: Bus writes presented while `sleep_i` is high have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, resets everything |
| dom_rst_n | input | 1 | Register-domain reset, active low, models supply loss |
| sleep_i | input | 1 | High while the system is in deep sleep |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Output enable per pad |
| pad_out | output | 8 | Output value per pad |
| pad_pull_en | output | 8 | Pull enable per pad |
| wake_req | output | 1 | Wake request during sleep |

## Verification
The assertions assume that `sleep_i` rises only while `dom_rst_n` is high, that a `dom_rst_n` pulse happens only while `sleep_i` is high, and that `bus_addr` changes only between clock edges. The stimulus keeps to this by driving every input on the falling clock edge. It raises `sleep_i` a few cycles before pulsing `dom_rst_n`, and drops `sleep_i` only after the domain reset has ended. Pin edges are held for several cycles, so that the two-flop synchroniser sees each level at least once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;
  localparam int CFG_N  = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR  = 3'd0,
    OFS_OUT  = 3'd1,
    OFS_PULL = 3'd2,
    OFS_EDGE = 3'd3,
    OFS_IE   = 3'd4,
    OFS_FLAG = 3'd5,
    OFS_LOCK = 3'd6,
    OFS_IN   = 3'd7
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] edge_sel,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] chain [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= pin_in;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  logic [WIDTH-1:0] cur, prev;
  assign cur   = chain[STAGES-1];
  assign prev  = chain[STAGES];
  assign level = cur;
  assign hit   = (~edge_sel & cur & ~prev) | (edge_sel & ~cur & prev);
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              cfg_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  dir,
  output logic [WIDTH-1:0]  dout,
  output logic [WIDTH-1:0]  pull,
  output logic [WIDTH-1:0]  edge_sel,
  output logic [WIDTH-1:0]  ie
);
  logic [WIDTH-1:0] regs [CFG_N];

  for (genvar g = 0; g < CFG_N; g++) begin : g_reg
    always_ff @(posedge clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n)                             regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))    regs[g] <= wr_data;
    end
  end

  assign dir      = regs[OFS_DIR];
  assign dout     = regs[OFS_OUT];
  assign pull     = regs[OFS_PULL];
  assign edge_sel = regs[OFS_EDGE];
  assign ie       = regs[OFS_IE];
endmodule

// File: rtl/gpio_pad_hold.sv
module gpio_pad_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             entry,
  input  logic [WIDTH-1:0] flags,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] dout,
  input  logic [WIDTH-1:0] pull,
  input  logic [WIDTH-1:0] edge_sel,
  input  logic [WIDTH-1:0] ie,
  output logic [WIDTH-1:0] eff_dir,
  output logic [WIDTH-1:0] eff_out,
  output logic [WIDTH-1:0] eff_pull,
  output logic [WIDTH-1:0] eff_edge,
  output logic [WIDTH-1:0] held_ie,
  output logic [WIDTH-1:0] entry_flags
);
  logic [WIDTH-1:0] h_dir, h_out, h_pull, h_edge, h_ie;

  // Transparent while unlocked, frozen while locked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_dir <= '0; h_out <= '0; h_pull <= '0; h_edge <= '0; h_ie <= '0;
    end else if (!lock) begin
      h_dir <= dir; h_out <= dout; h_pull <= pull; h_edge <= edge_sel; h_ie <= ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     entry_flags <= '0;
    else if (entry) entry_flags <= flags;
  end

  assign eff_dir  = lock ? h_dir  : dir;
  assign eff_out  = lock ? h_out  : dout;
  assign eff_pull = lock ? h_pull : pull;
  assign eff_edge = lock ? h_edge : edge_sel;
  assign held_ie  = h_ie;
endmodule

// File: rtl/gpio_sleep_port.sv
module gpio_sleep_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dom_rst_n,
  input  logic              sleep_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pull_en,
  output logic              wake_req
);
  logic             wr_ok, sleep_q, entry, lock_q, wake_q;
  logic             cfg_rst_n;
  logic [WIDTH-1:0] cfg_dir, cfg_out, cfg_pull, cfg_edge, cfg_ie;
  logic [WIDTH-1:0] eff_dir, eff_out, eff_pull, eff_edge, held_ie, entry_flags;
  logic [WIDTH-1:0] level, hit, flags_q, clr_mask;

  assign wr_ok     = bus_we && !sleep_i;
  assign cfg_rst_n = rst_n && dom_rst_n;
  assign entry     = sleep_i && !sleep_q;

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .wr_en(wr_ok), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .dir(cfg_dir), .dout(cfg_out), .pull(cfg_pull),
    .edge_sel(cfg_edge), .ie(cfg_ie)
  );

  gpio_pad_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .lock(lock_q), .entry(entry), .flags(flags_q),
    .dir(cfg_dir), .dout(cfg_out), .pull(cfg_pull), .edge_sel(cfg_edge), .ie(cfg_ie),
    .eff_dir(eff_dir), .eff_out(eff_out), .eff_pull(eff_pull), .eff_edge(eff_edge),
    .held_ie(held_ie), .entry_flags(entry_flags)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(eff_edge),
    .level(level), .hit(hit)
  );

  // Always-on domain: sleep tracker, lock, flags, wake latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lock_q <= 1'b0;
    else if (entry)                         lock_q <= 1'b1;
    else if (wr_ok && bus_addr == OFS_LOCK) lock_q <= bus_wdata[0];
  end

  assign clr_mask = (wr_ok && !lock_q && bus_addr == OFS_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (!sleep_i) wake_q <= 1'b0;
    else               wake_q <= wake_q | (|(hit & held_ie & ~entry_flags));
  end

  always_comb begin
    case (gpio_ofs_e'(bus_addr))
      OFS_DIR:  bus_rdata = cfg_dir;
      OFS_OUT:  bus_rdata = cfg_out;
      OFS_PULL: bus_rdata = cfg_pull;
      OFS_EDGE: bus_rdata = cfg_edge;
      OFS_IE:   bus_rdata = cfg_ie;
      OFS_FLAG: bus_rdata = flags_q;
      OFS_LOCK: bus_rdata = {{(WIDTH-1){1'b0}}, lock_q};
      default:  bus_rdata = level;
    endcase
  end

  assign pad_oe      = eff_dir;
  assign pad_out     = eff_out & eff_dir;
  assign pad_pull_en = eff_pull & ~eff_dir;
  assign wake_req    = wake_q;
endmodule

// File: rtl/gpio_sleep_port_checker.sv
module gpio_sleep_port_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dom_rst_n,
  input logic             sleep_i,
  input logic             lock_q,
  input logic [WIDTH-1:0] flags_q,
  input logic [WIDTH-1:0] cfg_dir,
  input logic [WIDTH-1:0] cfg_ie,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pull_en,
  input logic             wake_req
);
  assert_lock_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_i) |=> lock_q);

  assert_pads_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull_en)));

  assert_cfg_wiped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_rst_n |-> (cfg_dir == '0 && cfg_ie == '0));

  assert_flags_kept_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_wake_only_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_req);

  assert_pull_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pull_en) == '0);
endmodule

bind gpio_sleep_port gpio_sleep_port_checker #(.WIDTH(WIDTH)) u_checker (
  .clk(clk), .rst_n(rst_n), .dom_rst_n(dom_rst_n), .sleep_i(sleep_i),
  .lock_q(lock_q), .flags_q(flags_q), .cfg_dir(cfg_dir), .cfg_ie(cfg_ie),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en), .wake_req(wake_req)
);

// File: tb/gpio_sleep_port_bench.sv
module gpio_sleep_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0, dom_rst_n = 1'b1, sleep_i = 1'b0, bus_we = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0;
  logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_pull_en;
  logic         wake_req;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_sleep_port u_gpio_sleep_port (
    .clk(clk), .rst_n(rst_n), .dom_rst_n(dom_rst_n), .sleep_i(sleep_i),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .wake_req(wake_req)
  );

  // {dir, out, pull, exp_oe, exp_out, exp_pull}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'hA5, 8'hFF, 8'hFF, 8'hA5, 8'h00},
    {8'h0F, 8'h33, 8'hF0, 8'h0F, 8'h03, 8'hF0},
    {8'hF0, 8'h0F, 8'h3C, 8'hF0, 8'h00, 8'h0C},
    {8'h81, 8'h81, 8'h7E, 8'h81, 8'h81, 8'h7E},
    {8'h55, 8'hFF, 8'hAA, 8'h55, 8'h55, 8'hAA}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    ticks(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pads(input string req, input logic [W-1:0] oe,
                      input logic [W-1:0] o, input logic [W-1:0] p);
    check({req, " pad_oe"}, pad_oe, oe);
    check({req, " pad_out"}, pad_out, o);
    check({req, " pad_pull_en"}, pad_pull_en, p);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    @(negedge clk);
    ticks(2);
    rst_n = 1'b1;
    ticks(1);

    // R2: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); check("R2 reset readback", v, 8'h00);
    end
    pads("R2", 8'h00, 8'h00, 8'h00);
    check("R2 wake_req", {7'd0, wake_req}, 8'h00);

    // R1, R3: vector table
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, VEC[i][47:40]); wr(3'd1, VEC[i][39:32]); wr(3'd2, VEC[i][31:24]);
      rd(3'd0, v); check("R1 dir readback", v, VEC[i][47:40]);
      rd(3'd2, v); check("R1 pull readback", v, VEC[i][31:24]);
      pads("R3", VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R8: rising edge on pin 0 with edge select 0, timing
    wr(3'd3, 8'h00);
    pin_in = 8'h01;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(3'd5, v); check("R8 flag not before third edge", v, 8'h00);
    ticks(1);
    rd(3'd5, v); check("R8 rising flag", v, 8'h01);
    // R8: falling select on pin 1
    wr(3'd3, 8'h02);
    pin_in = 8'h03; ticks(4);
    rd(3'd5, v); check("R8 no flag on rise with select 1", v, 8'h01);
    pin_in = 8'h01; ticks(4);
    rd(3'd5, v); check("R8 falling flag", v, 8'h03);
    rd(3'd7, v); check("R1 pin level read", v, 8'h01);
    // R9: clear while unlocked
    wr(3'd5, 8'h03);
    rd(3'd5, v); check("R9 clear unlocked", v, 8'h00);

    // Pre-sleep setup: flag on pin 5 before entry, IE on pins 4 and 5
    wr(3'd3, 8'h00);
    pin_in = 8'h00; ticks(4);
    wr(3'd0, 8'h0F); wr(3'd1, 8'h05); wr(3'd2, 8'hF0); wr(3'd4, 8'h30);
    pin_in = 8'h20; ticks(4);
    pin_in = 8'h00; ticks(4);
    rd(3'd5, v); check("R8 pre-sleep flag", v, 8'h20);
    pads("R3 pre-sleep", 8'h0F, 8'h05, 8'hF0);

    // R4: sleep entry
    sleep_i = 1'b1; ticks(2);
    rd(3'd6, v); check("R4 lock set on entry", v, 8'h01);
    dom_rst_n = 1'b0; ticks(2);
    dom_rst_n = 1'b1; ticks(1);
    pads("R4 held through domain reset", 8'h0F, 8'h05, 8'hF0);
    rd(3'd0, v); check("R5 dir wiped", v, 8'h00);
    rd(3'd4, v); check("R5 ie wiped", v, 8'h00);
    rd(3'd6, v); check("R5 lock survives", v, 8'h01);
    rd(3'd5, v); check("R5 flags survive", v, 8'h20);
    // R12: writes ignored while asleep
    wr(3'd0, 8'hFF); wr(3'd6, 8'h00);
    rd(3'd0, v); check("R12 dir write ignored", v, 8'h00);
    rd(3'd6, v); check("R12 lock write ignored", v, 8'h01);

    // R10: pin 5 flag set at entry -> no wake; pin 6 not enabled -> no wake
    pin_in = 8'h20; ticks(4);
    check("R10 no wake from pre-flagged pin", {7'd0, wake_req}, 8'h00);
    pin_in = 8'h60; ticks(4);
    check("R10 no wake from disabled pin", {7'd0, wake_req}, 8'h00);
    pin_in = 8'h70; ticks(4);
    check("R10 wake from enabled pin", {7'd0, wake_req}, 8'h01);
    ticks(3);
    check("R10 wake stays high", {7'd0, wake_req}, 8'h01);
    rd(3'd5, v); check("R11 multiple flags", v, 8'h70);

    // Wake
    sleep_i = 1'b0; ticks(1);
    check("R10 wake drops after sleep ends", {7'd0, wake_req}, 8'h00);
    pads("R6 still held after wake", 8'h0F, 8'h05, 8'hF0);
    wr(3'd5, 8'hFF);
    rd(3'd5, v); check("R9 clear ignored while locked", v, 8'h70);
    wr(3'd0, 8'hF0); wr(3'd1, 8'hFF); wr(3'd2, 8'h0F);
    rd(3'd0, v); check("R6 dir readback while locked", v, 8'hF0);
    pads("R6 locked writes", 8'h0F, 8'h05, 8'hF0);

    // R7: release
    wr(3'd6, 8'h00);
    rd(3'd6, v); check("R7 lock cleared", v, 8'h00);
    pads("R7 pads follow registers", 8'hF0, 8'hF0, 8'h0F);
    rd(3'd5, v); check("R11 flags kept after wake", v, 8'h70);
    wr(3'd5, 8'hFF);
    rd(3'd5, v); check("R9 clear after release", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule